// File: doc/BRIEF.md
# Hot-Swap Fault Timer Sequencer

This block is the digital sequencer of a hot-swap gate controller. It takes the place of the analog timing capacitor with an up/down integrator counter and decides when the external pass transistor may be on. An analog loop elsewhere keeps the inrush current in check. This block limits how long the current may stay at its limit, and it also handles the power-up delay and the restart policy after a fault.

The inputs are a sampled overcurrent flag, a supply-good flag, an active-high enable pin, a software-off bit and a retry-mode strap. The enable pin first passes through a glitch filter. The state machine has five named states:
- OFF: the gate is off and the timer is cleared.
- INIT: the initial delay, during which the timer ramps at a slow power-up rate.
- ON: the gate is driven. The timer charges at the overcurrent rate while overcurrent is present and discharges fast once it clears.
- COOL: the gate is off and the timer drains at the slow rate toward an automatic restart.
- LATCH: the gate is held off after a fault.

The transitions are:
- power-up: OFF to INIT, when the supply is good and the effective enable is high.
- init-done: INIT to ON, when the timer reaches the trip level. The timer restarts from zero.
- trip-retry: ON to COOL, when the timer reaches the trip level while the retry strap is 1.
- trip-latch: ON to LATCH, when the timer reaches the trip level while the retry strap is 0.
- restart: COOL to ON, when the timer reaches zero.
- shutdown: any state to OFF, when the supply is lost or the effective enable is low.

Top module: `hsw_fault_seq`

## Requirements
- R1: After reset the gate output, the current-limit output and the fault output are all 0, and the enable filter output is low.
- R2: No start-up happens while pwr_good is 0. A fall of pwr_good forces gate_en to 0 in the same cycle.
- R3: Once pwr_good is 1 and the effective enable is high, gate_en rises exactly 1 + ceil(TRIP_LEVEL/INIT_STEP) clock edges later.
- R4: A change on en_pin that lasts fewer than FILT_CYCLES consecutive edges has no effect. A low lasting FILT_CYCLES edges drops gate_en at the FILT_CYCLES-th edge.
- R5: sw_off=1 acts like a filtered low enable. It drops gate_en in the same cycle and, when released, starts a new INIT.
- R6: In ON with oc_flag held at 1 from timer value r, gate_en falls at edge ceil((TRIP_LEVEL-r)/CHARGE_STEP). While gate_en and oc_flag are both 1, cur_lim is 1.
- R7: With oc_flag at 0 in ON, the timer drops by DISCHARGE_STEP per edge and stops at 0. A burst of n edges followed by m clear edges leaves max(0, n*CHARGE_STEP - m*DISCHARGE_STEP).
- R8: hs_fault is a single-cycle pulse, high in the cycle after the edge at which the trip happens.
- R9: With retry_mode=1, after a trip gate_en comes back on exactly ceil(TRIP_LEVEL/RETRY_STEP) edges later, without any INIT.
- R10: With retry_mode=0, after a trip gate_en stays 0 whatever oc_flag does, until the enable (or sw_off) is cycled. Start-up then follows R3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pwr_good | input | 1 | Supply above its start-up threshold |
| en_pin | input | 1 | Raw active-high enable, glitch filtered |
| sw_off | input | 1 | Software off request, same effect as a low enable |
| oc_flag | input | 1 | Sampled overcurrent comparator result |
| retry_mode | input | 1 | 1 selects automatic retry, 0 selects latched off |
| gate_en | output | 1 | Pass-transistor gate drive enable |
| cur_lim | output | 1 | Gate on while the current is at its limit |
| hs_fault | output | 1 | One-cycle pulse at a fault-timer trip |

## Verification
A timer value that is wrong in ON shows at the ports as a trip edge that is early or late. The sweep of overcurrent bursts and recovery gaps exposes this within the same burst, down to one edge. A wrong state after a trip shows as gate_en returning too early, never returning, or returning before the cooling count has ended. Filter or enable faults show as gate_en changing one or more edges away from the predicted edge.

// File: rtl/hsw_pkg.sv
package hsw_pkg;

    typedef enum logic [2:0] {
        S_OFF   = 3'd0,
        S_INIT  = 3'd1,
        S_ON    = 3'd2,
        S_COOL  = 3'd3,
        S_LATCH = 3'd4
    } hsw_state_e;

    typedef enum logic [2:0] {
        OP_HOLD   = 3'd0,
        OP_CLEAR  = 3'd1,
        OP_INIT   = 3'd2,
        OP_CHARGE = 3'd3,
        OP_FAST   = 3'd4,
        OP_SLOW   = 3'd5
    } tmr_op_e;

endpackage

// File: rtl/hsw_en_filter.sv
module hsw_en_filter #(
    parameter int FILT_CYCLES = 750
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_in,
    output logic filt_out
);
    localparam int CW = (FILT_CYCLES > 1) ? $clog2(FILT_CYCLES) : 1;
    localparam logic [CW-1:0] LAST = CW'(FILT_CYCLES - 1);

    logic [CW-1:0] run_cnt;

    // The output follows the input only after FILT_CYCLES edges without a break.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_cnt  <= '0;
            filt_out <= 1'b0;
        end else if (raw_in == filt_out) begin
            run_cnt <= '0;
        end else if (run_cnt == LAST) begin
            run_cnt  <= '0;
            filt_out <= raw_in;
        end else begin
            run_cnt <= run_cnt + 1'b1;
        end
    end
endmodule

// File: rtl/hsw_fault_timer.sv
module hsw_fault_timer
    import hsw_pkg::*;
#(
    parameter int TW             = 16,
    parameter int TRIP_LEVEL     = 39000,
    parameter int INIT_STEP      = 5,
    parameter int CHARGE_STEP    = 60,
    parameter int DISCHARGE_STEP = 100,
    parameter int RETRY_STEP     = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  tmr_op_e       op,
    output logic [TW-1:0] count,
    output logic          at_top,
    output logic          at_zero
);
    localparam logic [TW:0]   TOP_X   = (TW+1)'(TRIP_LEVEL);
    localparam logic [TW-1:0] TOP_V   = TW'(TRIP_LEVEL);

    logic [TW:0] step_x;
    logic [TW:0] sum_x;
    logic        going_up;
    logic        going_down;

    always_comb begin
        unique case (op)
            OP_INIT:   step_x = (TW+1)'(INIT_STEP);
            OP_CHARGE: step_x = (TW+1)'(CHARGE_STEP);
            OP_FAST:   step_x = (TW+1)'(DISCHARGE_STEP);
            OP_SLOW:   step_x = (TW+1)'(RETRY_STEP);
            default:   step_x = '0;
        endcase
        going_up   = (op == OP_INIT) || (op == OP_CHARGE);
        going_down = (op == OP_FAST) || (op == OP_SLOW);
        sum_x      = {1'b0, count} + step_x;
        at_top     = going_up && (sum_x >= TOP_X);
        at_zero    = going_down && ({1'b0, count} <= step_x);
    end

    // The end of the power-up ramp clears the count so the run starts from zero.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count <= '0;
        end else begin
            unique case (op)
                OP_CLEAR:  count <= '0;
                OP_INIT:   count <= at_top ? '0 : sum_x[TW-1:0];
                OP_CHARGE: count <= at_top ? TOP_V : sum_x[TW-1:0];
                OP_FAST,
                OP_SLOW:   count <= at_zero ? '0 : count - step_x[TW-1:0];
                default:   count <= count;
            endcase
        end
    end
endmodule

// File: rtl/hsw_fault_seq.sv
module hsw_fault_seq
    import hsw_pkg::*;
#(
    parameter int TW             = 16,
    parameter int TRIP_LEVEL     = 39000,
    parameter int INIT_STEP      = 5,
    parameter int CHARGE_STEP    = 60,
    parameter int DISCHARGE_STEP = 100,
    parameter int RETRY_STEP     = 2,
    parameter int FILT_CYCLES    = 750
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pwr_good,
    input  logic en_pin,
    input  logic sw_off,
    input  logic oc_flag,
    input  logic retry_mode,
    output logic gate_en,
    output logic cur_lim,
    output logic hs_fault
);
    hsw_state_e    state_q, state_d;
    tmr_op_e       op;
    logic          en_filt;
    logic          en_eff;
    logic          live;
    logic          trip;
    logic          fault_q;
    logic [TW-1:0] tmr_cnt;
    logic          tmr_top;
    logic          tmr_zero;

    hsw_en_filter #(.FILT_CYCLES(FILT_CYCLES)) u_filt (
        .clk      (clk),
        .rst_n    (rst_n),
        .raw_in   (en_pin),
        .filt_out (en_filt)
    );

    hsw_fault_timer #(
        .TW             (TW),
        .TRIP_LEVEL     (TRIP_LEVEL),
        .INIT_STEP      (INIT_STEP),
        .CHARGE_STEP    (CHARGE_STEP),
        .DISCHARGE_STEP (DISCHARGE_STEP),
        .RETRY_STEP     (RETRY_STEP)
    ) u_tmr (
        .clk     (clk),
        .rst_n   (rst_n),
        .op      (op),
        .count   (tmr_cnt),
        .at_top  (tmr_top),
        .at_zero (tmr_zero)
    );

    assign en_eff = en_filt & ~sw_off;
    assign live   = en_eff & pwr_good;

    // Timer operation for the current state
    always_comb begin
        if (!live) begin
            op = OP_CLEAR;
        end else begin
            unique case (state_q)
                S_OFF:   op = OP_CLEAR;
                S_INIT:  op = OP_INIT;
                S_ON:    op = oc_flag ? OP_CHARGE : OP_FAST;
                S_COOL:  op = OP_SLOW;
                S_LATCH: op = OP_HOLD;
                default: op = OP_CLEAR;
            endcase
        end
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        trip    = 1'b0;
        if (!live) begin
            state_d = S_OFF;                                  // shutdown
        end else begin
            unique case (state_q)
                S_OFF:   state_d = S_INIT;                    // power-up
                S_INIT:  if (tmr_top) state_d = S_ON;         // init-done
                S_ON: begin
                    if (oc_flag && tmr_top) begin
                        trip    = 1'b1;
                        state_d = retry_mode ? S_COOL : S_LATCH; // trip-retry / trip-latch
                    end
                end
                S_COOL:  if (tmr_zero) state_d = S_ON;        // restart
                S_LATCH: state_d = S_LATCH;
                default: state_d = S_OFF;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_OFF;
            fault_q <= 1'b0;
        end else begin
            state_q <= state_d;
            fault_q <= trip;
        end
    end

    // Outputs
    always_comb begin
        gate_en  = (state_q == S_ON) && live;
        cur_lim  = gate_en && oc_flag;
        hs_fault = fault_q;
    end
endmodule

// File: rtl/hsw_fault_seq_chk.sv
module hsw_fault_seq_chk
    import hsw_pkg::*;
#(
    parameter int TW         = 16,
    parameter int TRIP_LEVEL = 39000
) (
    input logic          clk,
    input logic          rst_n,
    input logic          pwr_good,
    input logic          en_eff,
    input logic          gate_en,
    input logic          hs_fault,
    input hsw_state_e    state_q,
    input logic [TW-1:0] tmr_cnt
);
    // R8: the fault output lasts a single cycle
    p_fault_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        hs_fault |=> !hs_fault);

    // R8: a fault only follows a cycle spent in ON
    p_fault_from_on_r8: assert property (@(posedge clk) disable iff (!rst_n)
        hs_fault |-> $past(state_q) == S_ON);

    // R6: the gate is already off when the fault pulse shows
    p_trip_gate_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
        hs_fault |-> !gate_en);

    // R6: the integrator never passes the trip level
    p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_cnt <= TW'(TRIP_LEVEL));

    // R2: a supply loss is followed by the OFF state
    p_supply_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pwr_good) |=> state_q == S_OFF);

    // R9: the cooling count only goes down
    p_cool_down_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_COOL && $past(state_q) == S_COOL) |-> tmr_cnt < $past(tmr_cnt));

    // R10: the latched state holds while supply and enable remain
    p_latch_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_LATCH && en_eff && pwr_good) |=> state_q == S_LATCH);
endmodule

bind hsw_fault_seq hsw_fault_seq_chk #(.TW(TW), .TRIP_LEVEL(TRIP_LEVEL)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .pwr_good (pwr_good),
    .en_eff   (en_eff),
    .gate_en  (gate_en),
    .hs_fault (hs_fault),
    .state_q  (state_q),
    .tmr_cnt  (tmr_cnt)
);

// File: tb/hsw_fault_seq_test.sv
module hsw_fault_seq_test;
    localparam int TRIP  = 600;
    localparam int INI   = 20;
    localparam int CHG   = 30;
    localparam int DIS   = 50;
    localparam int RTY   = 1;
    localparam int FILT  = 4;
    localparam int INIT_EDGES = 1 + (TRIP + INI - 1) / INI;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pwr_good = 1'b0, en_pin = 1'b0, sw_off = 1'b0, oc_flag = 1'b0, retry_mode = 1'b0;
    logic gate_en, cur_lim, hs_fault;
    int   n_cmp = 0;
    int   n_bad = 0;
    bit   done = 1'b0;

    always #2 clk = ~clk;

    hsw_fault_seq #(
        .TW(16), .TRIP_LEVEL(TRIP), .INIT_STEP(INI), .CHARGE_STEP(CHG),
        .DISCHARGE_STEP(DIS), .RETRY_STEP(RTY), .FILT_CYCLES(FILT)
    ) uut (
        .clk(clk), .rst_n(rst_n), .pwr_good(pwr_good), .en_pin(en_pin),
        .sw_off(sw_off), .oc_flag(oc_flag), .retry_mode(retry_mode),
        .gate_en(gate_en), .cur_lim(cur_lim), .hs_fault(hs_fault)
    );

    task automatic chk(input logic act, input logic exp, input string tag);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %b expected %b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    // gate_en must be off after edges-1 and on after edges
    task automatic expect_rise(input int edges, input string tag);
        tick(edges - 1);
        chk(gate_en, 1'b0, tag);
        tick(1);
        chk(gate_en, 1'b1, tag);
    endtask

    // Drive overcurrent until the trip edge k; check the edge, pulse and its end
    task automatic expect_trip(input int k, input string tag);
        oc_flag = 1'b1;
        if (k > 1) begin
            tick(k - 1);
            chk(gate_en, 1'b1, {tag, " R6 gate before trip"});
            chk(cur_lim, 1'b1, {tag, " R6 cur_lim"});
        end
        tick(1);
        chk(gate_en, 1'b0, {tag, " R6 gate at trip"});
        chk(hs_fault, 1'b1, {tag, " R8 fault high"});
        oc_flag = 1'b0;
        tick(1);
        chk(hs_fault, 1'b0, {tag, " R8 fault single"});
    endtask

    // Cycle the enable pin from a latched or running state
    task automatic cycle_enable(input string tag);
        en_pin = 1'b0;
        tick(FILT + 3);
        en_pin = 1'b1;
        expect_rise(FILT + INIT_EDGES, tag);
    endtask

    initial begin
        en_pin = 1'b1;
        tick(3);
        chk(gate_en, 1'b0, "R1 gate after reset");
        chk(cur_lim, 1'b0, "R1 cur_lim after reset");
        chk(hs_fault, 1'b0, "R1 fault after reset");
        rst_n = 1'b1;

        // R2: enable is up but the supply is not
        tick(20);
        chk(gate_en, 1'b0, "R2 no start without supply");
        pwr_good = 1'b1;
        expect_rise(INIT_EDGES, "R3 initial delay");

        // R2: supply loss drops the gate in the same cycle
        pwr_good = 1'b0;
        #1 chk(gate_en, 1'b0, "R2 supply loss immediate");
        tick(3);
        pwr_good = 1'b1;
        expect_rise(INIT_EDGES, "R3 delay after supply return");

        // R4: short enable glitch is ignored
        en_pin = 1'b0;
        for (int i = 0; i < FILT - 1; i++) begin
            tick(1);
            chk(gate_en, 1'b1, "R4 glitch ignored");
        end
        en_pin = 1'b1;
        tick(FILT + 2);
        chk(gate_en, 1'b1, "R4 still on after glitch");
        // R4: a held low acts at the FILT-th edge
        en_pin = 1'b0;
        tick(FILT - 1);
        chk(gate_en, 1'b1, "R4 on before filter expiry");
        tick(1);
        chk(gate_en, 1'b0, "R4 off at filter expiry");
        en_pin = 1'b1;
        expect_rise(FILT + INIT_EDGES, "R4 R3 restart after enable");

        // R5: software off
        sw_off = 1'b1;
        #1 chk(gate_en, 1'b0, "R5 sw_off immediate");
        tick(5);
        chk(gate_en, 1'b0, "R5 held off");
        sw_off = 1'b0;
        expect_rise(INIT_EDGES, "R5 restart after sw_off");

        // R6 R7 R8 R10: sweep bursts and recovery gaps in latched mode
        retry_mode = 1'b0;
        for (int n = 1; n < TRIP / CHG; n++) begin
            for (int m = 0; m <= 6; m++) begin
                int r;
                int k;
                oc_flag = 1'b1;
                tick(n);
                chk(gate_en, 1'b1, "R7 burst below trip");
                oc_flag = 1'b0;
                if (m > 0) begin
                    tick(m);
                    chk(gate_en, 1'b1, "R7 recovery");
                    chk(cur_lim, 1'b0, "R6 no cur_lim when clear");
                end
                r = n * CHG - m * DIS;
                if (r < 0) r = 0;
                k = (TRIP - r + CHG - 1) / CHG;
                expect_trip(k, "R7 sweep");
                tick(40);
                chk(gate_en, 1'b0, "R10 latched");
                cycle_enable("R10 R3 enable cycle");
            end
        end

        // R10: latched off ignores overcurrent changes; sw_off releases it
        expect_trip(TRIP / CHG, "R10 latch entry");
        oc_flag = 1'b1;
        tick(7);
        oc_flag = 1'b0;
        tick(500);
        chk(gate_en, 1'b0, "R10 latched long");
        chk(hs_fault, 1'b0, "R10 no further fault");
        sw_off = 1'b1;
        tick(2);
        sw_off = 1'b0;
        expect_rise(INIT_EDGES, "R10 R5 release via sw_off");

        // R9: automatic retry after the slow drain
        retry_mode = 1'b1;
        expect_trip(TRIP / CHG, "R9 retry trip");
        // one edge already spent after the trip
        expect_rise((TRIP + RTY - 1) / RTY - 1, "R9 retry restart");
        tick(10);
        chk(gate_en, 1'b1, "R9 stays on after retry");

        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: run did not complete");
            summary();
            $finish;
        end
    end
endmodule